// File: doc/BRIEF.md
# Root Port Error Message Collector

This block gathers error messages that arrive at a root port and turns them into root error status and an interrupt request. Each message carries a severity class (correctable, non-fatal or fatal) and a 16-bit requester identity. The collector keeps a set of sticky "received" flags, notes when a second error of the same kind arrives, remembers whether a fatal error was the first uncorrectable one, and holds the identity of the first correctable and the first uncorrectable sender since their flags were last cleared.

Software sees three registers through a simple write strobe and a combinational read port: a command register with one reporting enable per severity class, a write-one-to-clear status register that also shows the interrupt message number, and a read-only word with the two captured identities. The interrupt is a level in legacy mode and a one-cycle notify pulse in message-signalled mode. The message input is a valid/ready stream: `msg_ready` is low during reset and in the first cycle after it, then stays high, so a message is taken on every cycle where `msg_valid` and `msg_ready` are both high and the sender never has to hold a message for more than one cycle.

Top module: `root_err_collector`

## Requirements
- R1: After reset the command register, status flags, interrupt number and both captured identities read zero, and `irq_level` and `irq_pulse` are low. The command register (address 0) holds bits [2:0] = {fatal enable, non-fatal enable, correctable enable}; other bits read zero.
- R2: A correctable message (msg_sev = 0) sets the multiple-correctable flag (status bit 1) when the correctable flag (bit 0) is already set; otherwise it captures its identity. The correctable flag is then set.
- R3: A non-fatal (msg_sev = 1) or fatal (msg_sev = 2) message sets the multiple-uncorrectable flag (bit 3) when the uncorrectable flag (bit 2) is already set; otherwise it captures its identity. Bit 2 is then set.
- R4: A fatal message sets the first-fatal flag (bit 4) only when bit 2 was clear before it, and always sets the fatal flag (bit 6); a non-fatal message sets the non-fatal flag (bit 5).
- R5: Address 2 reads the correctable identity in bits [15:0] and the uncorrectable identity in bits [31:16]. Clearing status does not alter them.
- R6: Writing address 1 clears every status flag in bits [6:0] whose write bit is one. The interrupt number in bits [31:27] ignores writes; `vec_set` loads it from `vec_val`, and `irq_vec` shows it.
- R7: With `irq_msg_mode` low, `irq_level` is high exactly when some command enable is set together with its class flag (bit 0, bit 5 or bit 6); with `irq_msg_mode` high it is low.
- R8: With `irq_msg_mode` high, an accepted message raises `irq_pulse` for the next cycle only when its class is enabled and no enabled class was pending in the status it updates.
- R9: With `irq_msg_mode` high, a command write that enables a pending class while no previously enabled class was pending raises `irq_pulse` for the next cycle.
- R10: A message accepted in the same cycle as a status clear is applied to the cleared status.
- R11: `msg_ready` is high from the second cycle after reset; a message with msg_sev = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present |
| msg_ready | output | 1 | Collector accepts messages |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Requester identity of the message |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 status, 2 identities |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| vec_set | input | 1 | Load interrupt message number |
| vec_val | input | 5 | Interrupt message number to load |
| irq_msg_mode | input | 1 | 1: message-signalled pulse, 0: legacy level |
| irq_level | output | 1 | Legacy interrupt level |
| irq_pulse | output | 1 | Message-signalled notify pulse |
| irq_vec | output | 5 | Current interrupt message number |

## Verification
The bench goes after the repeat cases: a second correctable or uncorrectable message must leave the first identity in place and set only the multiple flag, and a design that overwrote the identity would show the later sender at address 2. A fatal message after a non-fatal one must leave first-fatal clear, which a design keyed on the fatal flag alone would get wrong. The notify pulse is driven through both the message path and the command-write path, including writes that enable an already pending class while another enabled class is pending, where a design that fired on every enabled arrival would pulse twice. The same-cycle clear and arrival is exercised so that a design applying the clear last would lose the new flag.

// File: rtl/rec_pkg.sv
package rec_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  typedef enum logic [1:0] {
    ADDR_CMD  = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_SRC  = 2'd2,
    ADDR_NONE = 2'd3
  } addr_e;

  localparam int FLAG_W  = 7;
  localparam int CLASS_W = 3;

  localparam int B_COR   = 0;
  localparam int B_MCOR  = 1;
  localparam int B_UNC   = 2;
  localparam int B_MUNC  = 3;
  localparam int B_FIRST = 4;
  localparam int B_NF    = 5;
  localparam int B_FATAL = 6;

  localparam int C_COR   = 0;
  localparam int C_NF    = 1;
  localparam int C_FATAL = 2;

  // Pending classes as seen by the command enables
  function automatic logic [CLASS_W-1:0] pend_classes(input logic [FLAG_W-1:0] f);
    logic [CLASS_W-1:0] p;
    p          = '0;
    p[C_COR]   = f[B_COR];
    p[C_NF]    = f[B_NF];
    p[C_FATAL] = f[B_FATAL];
    return p;
  endfunction

  function automatic logic [CLASS_W-1:0] sev_class(input sev_e s);
    logic [CLASS_W-1:0] c;
    c = '0;
    case (s)
      SEV_COR:      c[C_COR]   = 1'b1;
      SEV_NONFATAL: c[C_NF]    = 1'b1;
      SEV_FATAL:    c[C_FATAL] = 1'b1;
      default:      c          = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rec_status_unit.sv
module rec_status_unit
  import rec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              msg_fire,
  input  sev_e              msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic              vec_set,
  input  logic [VEC_W-1:0]  vec_val,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] base_flags,
  output logic [SRC_W-1:0]  cor_id_q,
  output logic [SRC_W-1:0]  unc_id_q,
  output logic [VEC_W-1:0]  vec_q
);

  logic [FLAG_W-1:0] flags_d;
  logic [SRC_W-1:0]  cor_id_d;
  logic [SRC_W-1:0]  unc_id_d;
  logic              is_unc;

  // Clear first, then the arriving message lands on the cleared image
  assign base_flags = flags_q & ~clr_mask;
  assign is_unc     = (msg_sev == SEV_NONFATAL) || (msg_sev == SEV_FATAL);

  always_comb begin
    flags_d  = base_flags;
    cor_id_d = cor_id_q;
    unc_id_d = unc_id_q;
    if (msg_fire) begin
      if (msg_sev == SEV_COR) begin
        if (base_flags[B_COR]) flags_d[B_MCOR] = 1'b1;
        else                   cor_id_d        = msg_src;
        flags_d[B_COR] = 1'b1;
      end
      if (msg_sev == SEV_FATAL) begin
        if (!base_flags[B_UNC]) flags_d[B_FIRST] = 1'b1;
        flags_d[B_FATAL] = 1'b1;
      end
      if (msg_sev == SEV_NONFATAL) flags_d[B_NF] = 1'b1;
      if (is_unc) begin
        if (base_flags[B_UNC]) flags_d[B_MUNC] = 1'b1;
        else                   unc_id_d        = msg_src;
        flags_d[B_UNC] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= '0;
      cor_id_q <= '0;
      unc_id_q <= '0;
      vec_q    <= '0;
    end else begin
      flags_q  <= flags_d;
      cor_id_q <= cor_id_d;
      unc_id_q <= unc_id_d;
      if (vec_set) vec_q <= vec_val;
    end
  end

endmodule

// File: rtl/rec_irq_unit.sv
module rec_irq_unit
  import rec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_mode,
  input  logic [CLASS_W-1:0] cmd_q,
  input  logic               cmd_wr,
  input  logic [CLASS_W-1:0] cmd_new,
  input  logic [FLAG_W-1:0]  flags_q,
  input  logic [FLAG_W-1:0]  base_flags,
  input  logic               msg_fire,
  input  sev_e               msg_sev,
  output logic               irq_level,
  output logic               irq_pulse
);

  logic [CLASS_W-1:0] pend_now;
  logic [CLASS_W-1:0] pend_base;
  logic               msg_notify;
  logic               cmd_notify;
  logic               pulse_d;

  assign pend_now  = pend_classes(flags_q);
  assign pend_base = pend_classes(base_flags);

  // Arrival notify: class enabled, nothing enabled was pending before it
  assign msg_notify = msg_fire && |(sev_class(msg_sev) & cmd_q) && !(|(pend_base & cmd_q));
  // Command notify: write newly uncovers a pending class
  assign cmd_notify = cmd_wr && !(|(cmd_q & pend_now)) && |(cmd_new & pend_now);
  assign pulse_d    = msg_mode && (msg_notify || cmd_notify);

  assign irq_level = !msg_mode && |(cmd_q & pend_now);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= pulse_d;
  end

endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             vec_set,
  input  logic [VEC_W-1:0] vec_val,
  input  logic             irq_msg_mode,
  output logic             irq_level,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec
);

  localparam int VEC_LSB = REG_W - VEC_W;

  logic [CLASS_W-1:0] cmd_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [FLAG_W-1:0]  base_flags;
  logic [FLAG_W-1:0]  clr_mask;
  logic [SRC_W-1:0]   cor_id_q;
  logic [SRC_W-1:0]   unc_id_q;
  logic [VEC_W-1:0]   vec_q;
  logic               ready_q;
  logic               msg_fire;
  logic               cmd_wr;
  logic               stat_wr;
  sev_e               sev;

  assign sev       = sev_e'(msg_sev);
  assign msg_ready = ready_q;
  assign msg_fire  = msg_valid && ready_q && (sev != SEV_RSVD);
  assign cmd_wr    = reg_wr_en && (addr_e'(reg_addr) == ADDR_CMD);
  assign stat_wr   = reg_wr_en && (addr_e'(reg_addr) == ADDR_STAT);
  assign clr_mask  = stat_wr ? reg_wdata[FLAG_W-1:0] : '0;
  assign irq_vec   = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (cmd_wr) cmd_q <= reg_wdata[CLASS_W-1:0];
    end
  end

  rec_status_unit #(
    .SRC_W(SRC_W),
    .VEC_W(VEC_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_mask  (clr_mask),
    .msg_fire  (msg_fire),
    .msg_sev   (sev),
    .msg_src   (msg_src),
    .vec_set   (vec_set),
    .vec_val   (vec_val),
    .flags_q   (flags_q),
    .base_flags(base_flags),
    .cor_id_q  (cor_id_q),
    .unc_id_q  (unc_id_q),
    .vec_q     (vec_q)
  );

  rec_irq_unit u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_mode  (irq_msg_mode),
    .cmd_q     (cmd_q),
    .cmd_wr    (cmd_wr),
    .cmd_new   (reg_wdata[CLASS_W-1:0]),
    .flags_q   (flags_q),
    .base_flags(base_flags),
    .msg_fire  (msg_fire),
    .msg_sev   (sev),
    .irq_level (irq_level),
    .irq_pulse (irq_pulse)
  );

  // Read multiplexer
  always_comb begin
    reg_rdata = '0;
    case (addr_e'(reg_addr))
      ADDR_CMD:  reg_rdata[CLASS_W-1:0] = cmd_q;
      ADDR_STAT: begin
        reg_rdata[FLAG_W-1:0]      = flags_q;
        reg_rdata[REG_W-1:VEC_LSB] = vec_q;
      end
      ADDR_SRC:  begin
        reg_rdata[SRC_W-1:0]       = cor_id_q;
        reg_rdata[2*SRC_W-1:SRC_W] = unc_id_q;
      end
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rec_checker.sv
module rec_checker
  import rec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int REG_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_sev,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq_msg_mode,
  input logic              irq_level,
  input logic              irq_pulse,
  input logic [FLAG_W-1:0] flags,
  input logic [SRC_W-1:0]  cor_id
);

  logic fire;
  logic swr;

  assign fire = msg_valid && msg_ready && (msg_sev != 2'd3);
  assign swr  = reg_wr_en && (reg_addr == 2'd1);

  AST_COR_ID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg_sev == 2'd0 && flags[B_COR] && !(swr && reg_wdata[B_COR]))
    |=> $stable(cor_id)); // R2

  AST_FIRST_FATAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && msg_sev == 2'd2 && flags[B_UNC] && !(swr && (reg_wdata[B_UNC] || reg_wdata[B_FIRST])))
    |=> (flags[B_FIRST] == $past(flags[B_FIRST]))); // R4

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !swr) |=> $stable(flags)); // R6

  AST_LEVEL_LEGACY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg_mode |-> !irq_level); // R7

  AST_PULSE_MSG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_msg_mode)); // R8

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !swr) |=> $stable(flags)); // R11

endmodule

bind root_err_collector rec_checker #(
  .SRC_W(SRC_W),
  .REG_W(REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_sev     (msg_sev),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq_msg_mode(irq_msg_mode),
  .irq_level   (irq_level),
  .irq_pulse   (irq_pulse),
  .flags       (flags_q),
  .cor_id      (cor_id_q)
);

// File: tb/root_err_collector_test.sv
module root_err_collector_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [1:0]  msg_sev = 2'd0;
  logic [15:0] msg_src = 16'h0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        vec_set = 1'b0;
  logic [4:0]  vec_val = 5'd0;
  logic        irq_msg_mode = 1'b0;
  logic        irq_level;
  logic        irq_pulse;
  logic [4:0]  irq_vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int mcmd = 0, mst = 0, mcor = 0, munc = 0, mvec = 0;
  bit mpulse = 0;

  always #(CLK_P/2) clk = ~clk;

  root_err_collector uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_sev(msg_sev), .msg_src(msg_src), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_set(vec_set), .vec_val(vec_val), .irq_msg_mode(irq_msg_mode),
    .irq_level(irq_level), .irq_pulse(irq_pulse), .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pend(input int s);
    return ((s >> 0) & 1) | (((s >> 5) & 1) << 1) | (((s >> 6) & 1) << 2);
  endfunction

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mcmd = 0; mst = 0; mcor = 0; munc = 0; mvec = 0; mpulse = 0;
    end else begin
      int base;
      int cls;
      bit note;
      note = 0;
      if (reg_wr_en && reg_addr == 2'd0 && irq_msg_mode &&
          (mcmd & pend(mst)) == 0 && (reg_wdata[2:0] & pend(mst)) != 0) note = 1;
      base = mst;
      if (reg_wr_en && reg_addr == 2'd1) base = mst & ~int'(reg_wdata[6:0]);
      if (msg_valid && msg_sev != 2'd3) begin
        cls = 1 << msg_sev;
        if (irq_msg_mode && (cls & mcmd) != 0 && (pend(base) & mcmd) == 0) note = 1;
        if (msg_sev == 2'd0) begin
          if (base & 1) base |= 2; else mcor = msg_src;
          base |= 1;
        end else begin
          if (msg_sev == 2'd2) begin
            if ((base & 4) == 0) base |= 16;
            base |= 64;
          end else base |= 32;
          if (base & 4) base |= 8; else munc = msg_src;
          base |= 4;
        end
      end
      if (reg_wr_en && reg_addr == 2'd0) mcmd = reg_wdata[2:0];
      if (vec_set) mvec = vec_val;
      mst = base;
      mpulse = note;
    end
  end

  // compare each cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      longint exp_rd;
      bit exp_lvl;
      case (reg_addr)
        2'd0: exp_rd = mcmd;
        2'd1: exp_rd = mst | (mvec << 27);
        2'd2: exp_rd = (munc << 16) | mcor;
        default: exp_rd = 0;
      endcase
      exp_lvl = !irq_msg_mode && ((mcmd & pend(mst)) != 0);
      chk(reg_rdata == exp_rd[31:0], (reg_addr == 0) ? "R1 model cmd" :
          (reg_addr == 1) ? "R2 model status" : "R5 model ids", reg_rdata, exp_rd);
      chk(irq_level == exp_lvl, "R7 model level", irq_level, exp_lvl);
      chk(irq_pulse == mpulse, "R8 model pulse", irq_pulse, mpulse);
      chk(irq_vec == mvec[4:0], "R6 model vector", irq_vec, mvec);
    end
  end

  task automatic idle();
    @(negedge clk);
    msg_valid = 0; reg_wr_en = 0; vec_set = 0;
  endtask

  task automatic send(input logic [1:0] s, input logic [15:0] id);
    @(negedge clk);
    msg_valid = 1; msg_sev = s; msg_src = id; reg_wr_en = 0; vec_set = 0;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; msg_valid = 0;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wr_en = 0; msg_valid = 0;
    @(posedge clk);
    #(CLK_P/4);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse_after_send(input logic [1:0] s, input logic [15:0] id,
                                  input bit exp, input string tag);
    @(negedge clk);
    msg_valid = 1; msg_sev = s; msg_src = id;
    @(posedge clk);
    #(CLK_P/4);
    chk(irq_pulse == exp, tag, irq_pulse, exp);
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic pulse_after_cmd(input logic [2:0] c, input bit exp, input string tag);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 2'd0; reg_wdata = {29'd0, c};
    @(posedge clk);
    #(CLK_P/4);
    chk(irq_pulse == exp, tag, irq_pulse, exp);
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(); idle();
    // R1 reset state
    rd(2'd0, 32'h0, "R1 cmd after reset");
    rd(2'd1, 32'h0, "R1 status after reset");
    rd(2'd2, 32'h0, "R1 ids after reset");
    chk(irq_level == 0 && irq_pulse == 0, "R1 irq low after reset", {irq_level, irq_pulse}, 0);
    chk(msg_ready == 1, "R11 ready high", msg_ready, 1);
    // R2 correctable repeat
    send(2'd0, 16'h1111);
    send(2'd0, 16'h2222);
    rd(2'd1, 32'h3, "R2 cor + multi");
    rd(2'd2, 32'h0000_1111, "R2 first cor id kept");
    // R3 / R4 uncorrectable
    send(2'd1, 16'hAAAA);
    send(2'd2, 16'hBBBB);
    rd(2'd1, 32'h6F, "R3 R4 nonfatal then fatal, no first-fatal");
    rd(2'd2, 32'hAAAA_1111, "R5 id word layout");
    // R6 clear and vector
    wr(2'd1, 32'h7F);
    rd(2'd1, 32'h0, "R6 w1c clears all flags");
    rd(2'd2, 32'hAAAA_1111, "R5 ids survive clear");
    @(negedge clk); vec_set = 1; vec_val = 5'h15;
    @(negedge clk); vec_set = 0;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'hA800_0000, "R6 vector loaded, not writable");
    chk(irq_vec == 5'h15, "R6 irq_vec", irq_vec, 5'h15);
    // R4 fatal first
    send(2'd2, 16'hCCCC);
    rd(2'd1, 32'hA800_0054, "R4 fatal first sets first-fatal");
    rd(2'd2, 32'hCCCC_1111, "R3 unc id captured");
    // R7 legacy level
    irq_msg_mode = 0;
    wr(2'd0, 32'h4);
    rd(2'd0, 32'h4, "R1 cmd readback");
    chk(irq_level == 1, "R7 level with fatal enabled", irq_level, 1);
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h1, "R1 cmd readback cor");
    chk(irq_level == 0, "R7 level with cor enabled only", irq_level, 0);
    wr(2'd1, 32'h7F);
    // R8 message-mode pulse
    @(negedge clk); irq_msg_mode = 1;
    pulse_after_send(2'd0, 16'h3333, 1, "R8 pulse on first enabled cor");
    chk(irq_level == 0, "R7 level low in message mode", irq_level, 0);
    pulse_after_send(2'd0, 16'h4444, 0, "R8 no pulse, already pending");
    pulse_after_send(2'd1, 16'h5555, 0, "R8 no pulse, class disabled");
    // R9 command-write pulse
    pulse_after_cmd(3'd3, 0, "R9 no pulse, enabled already pending");
    pulse_after_cmd(3'd0, 0, "R9 no pulse on disable");
    pulse_after_cmd(3'd2, 1, "R9 pulse, nonfatal newly enabled");
    // R10 clear and message together
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 2'd1; reg_wdata = 32'h7F;
    msg_valid = 1; msg_sev = 2'd0; msg_src = 16'h7777;
    @(negedge clk);
    reg_wr_en = 0; msg_valid = 0;
    rd(2'd1, 32'hA800_0001, "R10 message after clear");
    rd(2'd2, 32'h5555_7777, "R10 cor id recaptured");
    // R11 reserved severity
    send(2'd3, 16'h9999);
    rd(2'd1, 32'hA800_0001, "R11 reserved severity ignored");
    rd(2'd2, 32'h5555_7777, "R11 ids untouched");
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule